// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block sits on the host side of an SPI link to a slave whose registers are spread over several pages. Each request carries a combined address that holds a width code, a page number and an in-page register number, plus an operation: read, write or masked read-modify-write. The block turns each request into one or more SPI frames. It keeps a copy of the slave's active page, so a page-select frame goes out only when the requested page differs from that copy.

The main frame carries one address byte and then one or two data bytes, as the width code gives. Read data returns right-aligned with a single-cycle done pulse. A read-modify-write runs as one operation: the register is read, the masked value is merged in, and the result is written back before the next request can enter. Requests with an unusable width code or operation end at once with an error flag and send nothing on the wire.

The controller is a state machine with these states. C_IDLE accepts a request. From C_IDLE it goes to C_DONE for a bad request, to C_PAGE when the page differs from the cache, and to C_XFER otherwise. C_PAGE starts the page-select frame and C_PAGE_WAIT waits for it to end, then goes to C_XFER. C_XFER starts the main frame and C_XFER_WAIT waits for it. From C_XFER_WAIT a read-modify-write goes to C_MERGE, and every other operation goes to C_DONE. C_MERGE starts the write-back frame, and C_MERGE_WAIT waits for it and then goes to C_DONE. C_DONE pulses done for one cycle and returns to C_IDLE. The frame unit has four states: F_IDLE, F_LOAD (start the next byte), F_WAIT (wait for the byte to finish) and F_END (raise chip select and report done).

Top module: `pgreg_seq`

## Requirements
- R1: The request address is split as follows: bits 17:16 are the width code, bits 15:8 are the page and bits 7:0 are the in-page register number.
- R2: Before the main frame, a two-byte page-select frame (address byte 0x01, then the page byte) is sent only when the page in the request differs from the cached page. The cache takes the new page once that frame ends.
- R3: The page cache is 0 after reset, so a first access to page 0 sends no page-select frame.
- R4: A main frame is 1 + W bytes long, where W is the width code. Only W = 1 and W = 2 are valid.
- R5: A read is encoded as req_op = 0. Its address byte has bit 7 set and its data bytes are sent as 0x00. rsp_rdata is {8'h00, b1} for W = 1 and {b1, b2} for W = 2, where b1 is the first data byte returned.
- R6: A write is encoded as req_op = 1. It sends the register number unchanged as the address byte. For W = 2 it sends req_wdata[15:8] and then req_wdata[7:0]; for W = 1 it sends req_wdata[7:0] only. rsp_rdata is 0 after a write.
- R7: A read-modify-write is encoded as req_op = 2. It reads the register and then writes (old & ~req_mask) | (req_wdata & req_mask), with no other request accepted between the two frames. rsp_rdata returns the old value.
- R8: req_ready is high only while the block is idle. A request is taken when req_valid and req_ready are both high, and each accepted request gives exactly one single-cycle rsp_done pulse.
- R9: A width code of 0 or 3, or req_op = 3, ends the request with rsp_err high during the done pulse and rsp_rdata = 0. No frame is sent and the page cache is left unchanged.
- R10: The SPI runs in mode 0. spi_cs_n stays low for the whole frame, spi_sclk is low when idle, bits go MSB first, and spi_miso is sampled on the rising edge. Each half period of spi_sclk lasts HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 18 | Width code, page, register |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_wdata | input | 16 | Write value |
| req_mask | input | 16 | Bit mask for read-modify-write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| rsp_rdata | output | 16 | Right-aligned read data, valid with rsp_done |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
A bench model of the slave keeps its own page register and register array. A wrong page decision therefore shows up as data from, or data written to, the wrong register, not only as a wrong frame count. Requests alternate between pages in the same page, a new page, a return to page 0 and an odd page. This separates cached from uncached page handling and shows the cache starting at 0, including after a reset in the middle of a run. One-byte and two-byte registers are read and written to tell right-alignment and byte order apart. Read-modify-write with masks that clear and set bits in both halves shows that the merge uses the old value and returns it. Bad width codes and the reserved operation are followed by an access that would need a page-select frame if the rejected page had leaked into the cache.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    localparam int ADDR_W      = 18;
    localparam int DATA_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int DATA_BYTES  = FRAME_BYTES - 1;
    localparam int LEN_W       = $clog2(FRAME_BYTES + 1);
    localparam int WCODE_LSB   = 16;
    localparam int PAGE_LSB    = 8;

    localparam logic [BYTE_W-1:0] PAGE_SEL_ADDR = 8'h01;
    localparam logic [BYTE_W-1:0] READ_FLAG     = 8'h80;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        C_IDLE, C_PAGE, C_PAGE_WAIT, C_XFER,
        C_XFER_WAIT, C_MERGE, C_MERGE_WAIT, C_DONE
    } ctrl_state_e;

    typedef enum logic [1:0] {
        F_IDLE, F_LOAD, F_WAIT, F_END
    } frame_state_e;

    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0] frame_bytes_t;
    typedef logic [DATA_BYTES-1:0][BYTE_W-1:0]  data_bytes_t;
endpackage

// File: rtl/pgs_shifter.sv
module pgs_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          sclk_q;
    logic          busy_q;
    logic          done_q;
    logic          tick;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                sh_q   <= tx_byte;
                busy_q <= 1'b1;
                bit_q  <= '0;
                div_q  <= '0;
                sclk_q <= 1'b0;
            end else if (busy_q) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        sh_q   <= {sh_q[6:0], 1'b0};
                        bit_q  <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + CW'(1);
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = busy_q ? sh_q[7] : 1'b0;

    // R10
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> !sclk_q);
endmodule

// File: rtl/pgs_frame.sv
module pgs_frame
    import pgs_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LEN_W-1:0]     nbytes,
    input  frame_bytes_t         tx,
    input  logic                 miso,
    output logic                 idle,
    output logic                 done,
    output data_bytes_t          rx,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 mosi
);
    frame_state_e     state_q, state_d;
    frame_bytes_t     tx_q;
    logic [LEN_W-1:0] nb_q;
    logic [LEN_W-1:0] idx_q;
    logic             cs_n_q;
    logic             sh_start, sh_busy, sh_done;
    logic [7:0]       sh_rx;
    logic             last_byte;

    assign last_byte = (idx_q == nb_q - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: if (start) state_d = F_LOAD;
            F_LOAD: state_d = F_WAIT;
            F_WAIT: if (sh_done) state_d = last_byte ? F_END : F_LOAD;
            F_END:  state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            nb_q   <= '0;
            idx_q  <= '0;
            cs_n_q <= 1'b1;
        end else begin
            if (state_q == F_IDLE && start) begin
                tx_q   <= tx;
                nb_q   <= nbytes;
                idx_q  <= '0;
                cs_n_q <= 1'b0;
            end else if (state_q == F_WAIT && sh_done) begin
                if (last_byte) cs_n_q <= 1'b1;
                else           idx_q  <= idx_q + LEN_W'(1);
            end
        end
    end

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_rx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rx[b] <= '0;
            else if (state_q == F_WAIT && sh_done && idx_q == LEN_W'(b + 1))
                rx[b] <= sh_rx;
        end
    end

    assign sh_start = (state_q == F_LOAD);
    assign idle     = (state_q == F_IDLE);
    assign done     = (state_q == F_END);
    assign cs_n     = cs_n_q;

    pgs_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_q[idx_q]),
        .miso    (miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (sclk),
        .mosi    (mosi)
    );

    // R10
    cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !cs_n_q);
endmodule

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              f_start,
    output logic [LEN_W-1:0]  f_nbytes,
    output frame_bytes_t      f_tx,
    input  logic              f_idle,
    input  logic              f_done,
    input  data_bytes_t       f_rx
);
    ctrl_state_e       state_q, state_d;
    op_e               op_q;
    logic [1:0]        wcode_q;
    logic [7:0]        tgt_page_q;
    logic [7:0]        reg_q;
    logic [DATA_W-1:0] wdata_q, mask_q, rdata_q, merged_q;
    logic [7:0]        cache_q;
    logic              err_q;
    logic              accept, bad_req;
    logic [1:0]        in_wcode;
    logic [7:0]        in_page;
    logic [DATA_W-1:0] rx_aligned;

    assign in_wcode = req_addr[WCODE_LSB +: 2];
    assign in_page  = req_addr[PAGE_LSB +: 8];
    assign accept   = req_valid && (state_q == C_IDLE);
    assign bad_req  = (in_wcode == 2'd0) || (in_wcode == 2'd3) || (op_e'(req_op) == OP_RSVD);

    function automatic frame_bytes_t pack_write(input logic [7:0] a,
                                                input logic [1:0] w,
                                                input logic [DATA_W-1:0] v);
        frame_bytes_t fb;
        fb    = '0;
        fb[0] = a;
        if (w == 2'd1) begin
            fb[1] = v[7:0];
        end else begin
            fb[1] = v[15:8];
            fb[2] = v[7:0];
        end
        return fb;
    endfunction

    assign rx_aligned = (wcode_q == 2'd1) ? {8'h00, f_rx[0]} : {f_rx[0], f_rx[1]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:       if (accept) state_d = bad_req ? C_DONE :
                                      (in_page != cache_q) ? C_PAGE : C_XFER;
            C_PAGE:       state_d = C_PAGE_WAIT;
            C_PAGE_WAIT:  if (f_done) state_d = C_XFER;
            C_XFER:       state_d = C_XFER_WAIT;
            C_XFER_WAIT:  if (f_done) state_d = (op_q == OP_RMW) ? C_MERGE : C_DONE;
            C_MERGE:      state_d = C_MERGE_WAIT;
            C_MERGE_WAIT: if (f_done) state_d = C_DONE;
            C_DONE:       state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            wcode_q    <= '0;
            tgt_page_q <= '0;
            reg_q      <= '0;
            wdata_q    <= '0;
            mask_q     <= '0;
            rdata_q    <= '0;
            merged_q   <= '0;
            cache_q    <= '0;
            err_q      <= 1'b0;
        end else begin
            if (accept) begin
                op_q       <= op_e'(req_op);
                wcode_q    <= in_wcode;
                tgt_page_q <= in_page;
                reg_q      <= req_addr[7:0];
                wdata_q    <= req_wdata;
                mask_q     <= req_mask;
                err_q      <= bad_req;
                rdata_q    <= '0;
            end
            if (state_q == C_PAGE_WAIT && f_done)
                cache_q <= tgt_page_q;
            if (state_q == C_XFER_WAIT && f_done && op_q != OP_WRITE) begin
                rdata_q  <= rx_aligned;
                merged_q <= (rx_aligned & ~mask_q) | (wdata_q & mask_q);
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        f_start   = 1'b0;
        f_nbytes  = '0;
        f_tx      = '0;
        unique case (state_q)
            C_IDLE: req_ready = 1'b1;
            C_PAGE: begin
                f_start  = 1'b1;
                f_nbytes = LEN_W'(2);
                f_tx[0]  = PAGE_SEL_ADDR;
                f_tx[1]  = tgt_page_q;
            end
            C_XFER: begin
                f_start  = 1'b1;
                f_nbytes = LEN_W'(wcode_q) + LEN_W'(1);
                if (op_q == OP_WRITE)
                    f_tx = pack_write(reg_q, wcode_q, wdata_q);
                else
                    f_tx[0] = reg_q | READ_FLAG;
            end
            C_MERGE: begin
                f_start  = 1'b1;
                f_nbytes = LEN_W'(wcode_q) + LEN_W'(1);
                f_tx     = pack_write(reg_q, wcode_q, merged_q);
            end
            C_DONE: begin
                rsp_done = 1'b1;
                rsp_err  = err_q;
            end
            C_PAGE_WAIT, C_XFER_WAIT, C_MERGE_WAIT: ;
        endcase
    end

    assign rsp_rdata = rdata_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R9
    err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_start |-> !err_q);
    // R2
    cache_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cache_q) |-> $past(state_q == C_PAGE_WAIT && f_done));
    // R10
    frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_start |-> f_idle);
    // R7
    rmw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_XFER_WAIT && f_done && op_q == OP_RMW) |=> !req_ready);
endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
    import pgs_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic             f_start, f_idle, f_done;
    logic [LEN_W-1:0] f_nbytes;
    frame_bytes_t     f_tx;
    data_bytes_t      f_rx;

    pgs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_op    (req_op),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .f_start   (f_start),
        .f_nbytes  (f_nbytes),
        .f_tx      (f_tx),
        .f_idle    (f_idle),
        .f_done    (f_done),
        .f_rx      (f_rx)
    );

    pgs_frame #(.HALF_DIV(HALF_DIV)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (f_start),
        .nbytes (f_nbytes),
        .tx     (f_tx),
        .miso   (spi_miso),
        .idle   (f_idle),
        .done   (f_done),
        .rx     (f_rx),
        .cs_n   (spi_cs_n),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi)
    );
endmodule

// File: tb/tb_pgreg_seq.sv
`timescale 1ns/1ps
module tb_pgreg_seq;
    localparam int HALF = 2;
    localparam int NV   = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_mask = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    pgreg_seq #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- slave model ----------------
    logic [15:0] smem [0:4095];
    logic [7:0]  s_page = '0;
    logic [7:0]  s_rx = '0, s_addr = '0, s_out = '0;
    logic        s_rd = 1'b0;
    logic [15:0] s_tx = '0;
    int          s_bits = 0, s_k = 0;
    int          frames = 0, last_len = 0, fill_bad = 0, half_bad = 0;
    time         t_rise = 0;

    function automatic int sidx(input logic [7:0] pg, input logic [7:0] rg);
        return int'({pg[4:0], rg[6:0]});
    endfunction

    assign spi_miso = s_out[7];

    always @(negedge spi_cs_n) begin
        frames = frames + 1;
        s_bits = 0;
        s_out  = '0;
    end
    always @(posedge spi_cs_n) last_len = s_bits / 8;

    always @(posedge spi_sclk) begin
        t_rise = $time;
        if (!spi_cs_n) begin
            s_rx   = {s_rx[6:0], spi_mosi};
            s_bits = s_bits + 1;
            if (s_bits % 8 == 0) begin
                s_k = s_bits / 8;
                if (s_k == 1) begin
                    s_addr = s_rx;
                    s_rd   = s_rx[7];
                    s_tx   = smem[sidx(s_page, s_rx)];
                end else if (s_rd) begin
                    if (s_rx != 8'h00) fill_bad = fill_bad + 1;
                end else if (s_addr == 8'h01) begin
                    if (s_k == 2) s_page = s_rx;
                end else if (s_k == 2) begin
                    smem[sidx(s_page, s_addr)][15:8] = s_rx;
                end else if (s_k == 3) begin
                    smem[sidx(s_page, s_addr)][7:0] = s_rx;
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if ($time - t_rise != HALF * 20) half_bad = half_bad + 1;
        if (!spi_cs_n) begin
            if (s_bits % 8 == 0) begin
                s_k   = s_bits / 8;
                s_out = (s_k == 1) ? s_tx[15:8] : (s_k == 2) ? s_tx[7:0] : 8'h00;
            end else begin
                s_out = {s_out[6:0], 1'b0};
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0, cycles = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        s_page = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_req(input logic [1:0] op, input logic [17:0] addr,
                           input logic [15:0] wd, input logic [15:0] mk,
                           output logic [15:0] rd, output logic er,
                           output int nfr, output int len);
        int f0;
        int guard;
        guard = 0;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        f0 = frames;
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 ready low after accept", 32'(req_ready), 32'd0);
        guard = 0;
        while (!rsp_done && guard < 5000) begin @(negedge clk); guard++; end
        rd  = rsp_rdata;
        er  = rsp_err;
        nfr = frames - f0;
        len = last_len;
        @(negedge clk);
        chk("R8 single done pulse", 32'(rsp_done), 32'd0);
        chk("R10 idle lines", {30'd0, spi_cs_n, spi_sclk}, 32'd2);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [17:0] addr;
        logic [15:0] wd;
        logic [15:0] mk;
        logic [15:0] ex_rd;
        logic        ex_err;
        logic [1:0]  ex_fr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 18'h20010, 16'h0000, 16'h0000, 16'hA55A, 1'b0, 2'd1},
        '{2'd0, 18'h10004, 16'h0000, 16'h0000, 16'h003C, 1'b0, 2'd1},
        '{2'd0, 18'h20214, 16'h0000, 16'h0000, 16'h1234, 1'b0, 2'd2},
        '{2'd0, 18'h20214, 16'h0000, 16'h0000, 16'h1234, 1'b0, 2'd1},
        '{2'd1, 18'h20215, 16'hBEEF, 16'h0000, 16'h0000, 1'b0, 2'd1},
        '{2'd0, 18'h20215, 16'h0000, 16'h0000, 16'hBEEF, 1'b0, 2'd1},
        '{2'd2, 18'h20214, 16'hFFFF, 16'h00F0, 16'h1234, 1'b0, 2'd2},
        '{2'd0, 18'h20214, 16'h0000, 16'h0000, 16'h12F4, 1'b0, 2'd1},
        '{2'd2, 18'h10E10, 16'h0081, 16'h0081, 16'h007F, 1'b0, 2'd3},
        '{2'd0, 18'h10E10, 16'h0000, 16'h0000, 16'h00FF, 1'b0, 2'd1},
        '{2'd0, 18'h20010, 16'h0000, 16'h0000, 16'hA55A, 1'b0, 2'd2},
        '{2'd0, 18'h00510, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd0},
        '{2'd0, 18'h20010, 16'h0000, 16'h0000, 16'hA55A, 1'b0, 2'd1},
        '{2'd1, 18'h30010, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd0},
        '{2'd3, 18'h20010, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd0},
        '{2'd1, 18'h10004, 16'hAB12, 16'h0000, 16'h0000, 1'b0, 2'd1},
        '{2'd0, 18'h10004, 16'h0000, 16'h0000, 16'h0012, 1'b0, 2'd1},
        '{2'd0, 18'h20010, 16'h0000, 16'h0000, 16'hA55A, 1'b0, 2'd1}
    };

    function automatic string data_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R5 read data";
            2'd1:    return "R6 write response";
            2'd2:    return "R7 rmw old value";
            default: return "R9 rejected data";
        endcase
    endfunction

    initial begin
        logic [15:0] rd;
        logic        er;
        int          nfr, len;
        for (int i = 0; i < 4096; i++) smem[i] = '0;
        smem[sidx(8'h00, 8'h10)] = 16'hA55A;
        smem[sidx(8'h00, 8'h04)] = 16'h3C00;
        smem[sidx(8'h02, 8'h14)] = 16'h1234;
        smem[sidx(8'h0E, 8'h10)] = 16'h7F00;

        do_reset();
        chk("R8 ready after reset", 32'(req_ready), 32'd1);
        chk("R10 cs_n high after reset", 32'(spi_cs_n), 32'd1);
        chk("R10 sclk low after reset", 32'(spi_sclk), 32'd0);
        chk("R8 no done after reset", 32'(rsp_done), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_req(VECS[v].op, VECS[v].addr, VECS[v].wd, VECS[v].mk, rd, er, nfr, len);
            chk(data_tag(VECS[v].op), 32'(rd), 32'(VECS[v].ex_rd));
            chk("R9 error flag", 32'(er), 32'(VECS[v].ex_err));
            chk("R1/R2 frame count", 32'(nfr), 32'(VECS[v].ex_fr));
            if (!VECS[v].ex_err)
                chk("R4 frame length", 32'(len), 32'(1 + int'(VECS[v].addr[17:16])));
        end

        chk("R5 zero fill on reads", 32'(fill_bad), 32'd0);

        // reset in mid-run: cache must fall back to page 0
        run_req(2'd0, 18'h20214, 16'h0, 16'h0, rd, er, nfr, len);
        chk("R2 page select before reset", 32'(nfr), 32'd2);
        do_reset();
        run_req(2'd0, 18'h20010, 16'h0, 16'h0, rd, er, nfr, len);
        chk("R3 cache zero after reset", 32'(nfr), 32'd1);
        chk("R3 data after reset", 32'(rd), 32'hA55A);
        run_req(2'd0, 18'h20214, 16'h0, 16'h0, rd, er, nfr, len);
        chk("R3 page change after reset", 32'(nfr), 32'd2);
        chk("R5 read after reset", 32'(rd), 32'h12F4);

        chk("R10 half period", 32'(half_bad), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule